// File: doc/BRIEF.md
# Single-Cycle 16-bit RISC Processor Core

This block is a compact 16-bit processor that finishes every instruction in one clock. Instruction and data memories sit on separate ports: each clock the core presents the program counter on a word-addressed instruction port and takes the 16-bit word that comes back. The instruction is decoded, executed and retired before the next rising edge. Data accesses use a second word-addressed port with address, write data, write enable and read data. A keyboard port and a character output port give the core simple input and output.

The core has eight 16-bit general registers. Register 0 always reads as zero. Instruction words carry a 4-bit operation code in the top nibble and 3-bit register selectors. Arithmetic, loads and branches take a 6-bit signed offset. Jump targets are 12 bits. A combinational decoder turns the operation code into the steering controls for next-PC selection, destination choice, operand choice, ALU function, memory write, write-back source and the two I/O strobes. The memories and the I/O devices sit outside the block.

Top module: `cpu16_core`

## Requirements
- R1: While reset is low, the program counter and registers r1..r7 are held at zero, and `imem_addr` reads 0 throughout reset.
- R2: Bits [15:12] are the operation code. rs=[11:9], rt=[8:6], rd=[5:3]. The codes are 1=add, 2=sub, 3=not, 4=and, and each writes rd with rs+rt, rs-rt, ~rs or rs&rt (16-bit, wrapping).
- R3: Code 0 (addi) writes rt with rs plus the sign-extended offset in [5:0]. Code 7 (lw) writes rt with the RAM word at rs plus the sign-extended offset, and `dmem_addr` carries that sum.
- R4: Code 5 shifts rs left and code 6 shifts rs right with zero fill, by the 3-bit amount in [2:0], and the result goes to rd.
- R5: Code 8 (sw) drives `dmem_we` high for exactly that cycle, with `dmem_addr` = rs + sign-extended offset and `dmem_wdata` = rt. It writes no register, and the stored word is visible to a load in the next cycle.
- R6: Code 9 branches when rs bit 15 is 0. Code 10 branches when rs equals rt. A taken branch sets PC to PC+1+sign-extended offset; otherwise PC becomes PC+1.
- R7: Code 11 sets PC to the 12-bit field [11:0] with the upper four bits cleared. Code 12 sets PC to rs.
- R8: Code 13 writes PC+1 into r7 and sets PC to the zero-extended 12-bit field in the same cycle.
- R9: Code 14 copies `kbd_data` into rd without waiting. `kbd_rd` is high in that cycle and in no other.
- R10: Code 15 drives `tty_data` with rs[6:0]. `tty_we` is high in that cycle and in no other, and no register is written.
- R11: Writes to r0 are discarded and r0 reads as zero.
- R12: Any instruction that is not a taken branch or a jump advances PC by one, wrapping at 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 16 | Program counter, word address of the instruction |
| imem_data | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | 16 | Data RAM word address |
| dmem_wdata | output | 16 | Data RAM store data |
| dmem_we | output | 1 | Data RAM write enable, taken at the rising edge |
| dmem_rdata | input | 16 | Data RAM word at `dmem_addr` |
| kbd_data | input | 16 | Current keyboard value |
| kbd_rd | output | 1 | Keyboard read strobe |
| tty_data | output | 7 | Character for the output device |
| tty_we | output | 1 | Output device write strobe |

## Verification
A call (code 13) makes two things happen in one cycle: it writes r7 with the return address, and it redirects the program counter. Both must reflect the pre-instruction PC. A directed program provokes this with a call into a routine that does output and input and returns through r7. It stores r7 after the return, and the stored value and the PC trace are compared with hand-derived numbers. Random instruction streams put calls beside returns, stores and r7-sourced operations. A bench instruction-level model runs in lockstep and judges every cycle's PC, memory write and strobes.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

  localparam int WORD_W    = 16;
  localparam int REG_CNT   = 8;
  localparam int REG_IDX_W = $clog2(REG_CNT);
  localparam int OPC_W     = 4;
  localparam int IMM_W     = 6;
  localparam int JADDR_W   = 12;
  localparam int SHAMT_W   = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_ADDI = 4'h0, OP_ADD = 4'h1, OP_SUB = 4'h2, OP_NOT = 4'h3,
    OP_AND  = 4'h4, OP_SLL = 4'h5, OP_SRL = 4'h6, OP_LW  = 4'h7,
    OP_SW   = 4'h8, OP_BGEZ = 4'h9, OP_BEQ = 4'hA, OP_J  = 4'hB,
    OP_JR   = 4'hC, OP_JAL = 4'hD, OP_IN  = 4'hE, OP_OUT = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_NOT, ALU_AND, ALU_SLL, ALU_SRL
  } alu_fn_e;

  typedef enum logic [1:0] {NXT_SEQ, NXT_BRANCH, NXT_JUMP, NXT_REG} nxt_sel_e;
  typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK}               dst_sel_e;
  typedef enum logic [1:0] {OPB_RT, OPB_IMM, OPB_SHAMT, OPB_ZERO}   opb_sel_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK, WB_KEY}        wb_sel_e;

  typedef struct packed {
    nxt_sel_e nxt_sel;
    dst_sel_e dst_sel;
    logic     reg_we;
    opb_sel_e opb_sel;
    alu_fn_e  alu_fn;
    logic     mem_we;
    wb_sel_e  wb_sel;
    logic     key_re;
    logic     tty_we;
  } ctrl_t;

  function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

endpackage

// File: rtl/cpu16_decode.sv
module cpu16_decode
  import cpu16_pkg::*;
(
  input  opcode_e op,
  output ctrl_t   ctrl
);

  always_comb begin
    ctrl = '{nxt_sel: NXT_SEQ, dst_sel: DST_RD, reg_we: 1'b0, opb_sel: OPB_RT,
             alu_fn: ALU_ADD, mem_we: 1'b0, wb_sel: WB_ALU, key_re: 1'b0,
             tty_we: 1'b0};
    case (op)
      OP_ADDI: begin ctrl.dst_sel = DST_RT; ctrl.reg_we = 1'b1; ctrl.opb_sel = OPB_IMM; end
      OP_ADD:  ctrl.reg_we = 1'b1;
      OP_SUB:  begin ctrl.reg_we = 1'b1; ctrl.alu_fn = ALU_SUB; end
      OP_NOT:  begin ctrl.reg_we = 1'b1; ctrl.alu_fn = ALU_NOT; end
      OP_AND:  begin ctrl.reg_we = 1'b1; ctrl.alu_fn = ALU_AND; end
      OP_SLL:  begin ctrl.reg_we = 1'b1; ctrl.opb_sel = OPB_SHAMT; ctrl.alu_fn = ALU_SLL; end
      OP_SRL:  begin ctrl.reg_we = 1'b1; ctrl.opb_sel = OPB_SHAMT; ctrl.alu_fn = ALU_SRL; end
      OP_LW:   begin
        ctrl.dst_sel = DST_RT; ctrl.reg_we = 1'b1; ctrl.opb_sel = OPB_IMM; ctrl.wb_sel = WB_MEM;
      end
      OP_SW:   begin ctrl.opb_sel = OPB_IMM; ctrl.mem_we = 1'b1; end
      OP_BGEZ: begin ctrl.nxt_sel = NXT_BRANCH; ctrl.opb_sel = OPB_ZERO; end
      OP_BEQ:  begin ctrl.nxt_sel = NXT_BRANCH; ctrl.alu_fn = ALU_SUB; end
      OP_J:    ctrl.nxt_sel = NXT_JUMP;
      OP_JR:   ctrl.nxt_sel = NXT_REG;
      OP_JAL:  begin
        ctrl.nxt_sel = NXT_JUMP; ctrl.dst_sel = DST_LINK; ctrl.reg_we = 1'b1; ctrl.wb_sel = WB_LINK;
      end
      OP_IN:   begin ctrl.reg_we = 1'b1; ctrl.wb_sel = WB_KEY; ctrl.key_re = 1'b1; end
      OP_OUT:  ctrl.tty_we = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero,
  output logic         neg
);

  localparam int SH_W = $clog2(W);

  function automatic logic [W-1:0] alu_eval(input logic [W-1:0] x,
                                            input logic [W-1:0] z,
                                            input alu_fn_e f);
    case (f)
      ALU_ADD: return x + z;
      ALU_SUB: return x - z;
      ALU_NOT: return ~x;
      ALU_AND: return x & z;
      ALU_SLL: return x << z[SH_W-1:0];
      ALU_SRL: return x >> z[SH_W-1:0];
      default: return '0;
    endcase
  endfunction

  always_comb begin
    y    = alu_eval(a, b, fn);
    zero = (y == '0);
    neg  = y[W-1];
  end

endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile
  import cpu16_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = REG_CNT,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] ra,
  input  logic [IW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb,
  input  logic          we,
  input  logic [IW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] bank [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign bank[i] = '0;
    end else begin : g_store
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     q <= '0;
        else if (we && wa == IW'(i))    q <= wd;
      end
      assign bank[i] = q;
    end
  end

  assign qa = bank[ra];
  assign qb = bank[rb];

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] imem_addr,
  input  logic [W-1:0] imem_data,
  output logic [W-1:0] dmem_addr,
  output logic [W-1:0] dmem_wdata,
  output logic         dmem_we,
  input  logic [W-1:0] dmem_rdata,
  input  logic [W-1:0] kbd_data,
  output logic         kbd_rd,
  output logic [6:0]   tty_data,
  output logic         tty_we
);

  localparam int IW = REG_IDX_W;
  localparam logic [IW-1:0] LINK_REG = IW'(REG_CNT - 1);

  logic [W-1:0]  pc, pc_plus1, pc_next, br_target, jmp_target;
  opcode_e       op;
  logic [IW-1:0] f_rs, f_rt, f_rd;
  logic [W-1:0]  imm_ext, shamt_ext;
  ctrl_t         ctrl;

  // named internal events, observed by the checker
  logic [W-1:0]  rs_val, rt_val, alu_b, alu_y;
  logic          alu_zero, alu_neg, br_cond, pc_redirect;
  logic          rf_we;
  logic [IW-1:0] rf_waddr;
  logic [W-1:0]  rf_wdata;

  assign op         = opcode_e'(imem_data[15:12]);
  assign f_rs       = imem_data[11:9];
  assign f_rt       = imem_data[8:6];
  assign f_rd       = imem_data[5:3];
  assign imm_ext    = sext_imm(imem_data[IMM_W-1:0]);
  assign shamt_ext  = W'(imem_data[SHAMT_W-1:0]);
  assign jmp_target = W'(imem_data[JADDR_W-1:0]);
  assign pc_plus1   = pc + W'(1);
  assign br_target  = pc_plus1 + imm_ext;

  cpu16_decode u_dec (.op(op), .ctrl(ctrl));

  cpu16_regfile #(.W(W), .N(REG_CNT)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra(f_rs), .rb(f_rt), .qa(rs_val), .qb(rt_val),
    .we(rf_we), .wa(rf_waddr), .wd(rf_wdata)
  );

  always_comb begin
    case (ctrl.opb_sel)
      OPB_IMM:   alu_b = imm_ext;
      OPB_SHAMT: alu_b = shamt_ext;
      OPB_ZERO:  alu_b = '0;
      default:   alu_b = rt_val;
    endcase
  end

  cpu16_alu #(.W(W)) u_alu (
    .a(rs_val), .b(alu_b), .fn(ctrl.alu_fn),
    .y(alu_y), .zero(alu_zero), .neg(alu_neg)
  );

  // write-back steering
  always_comb begin
    rf_we = ctrl.reg_we;
    case (ctrl.dst_sel)
      DST_RT:   rf_waddr = f_rt;
      DST_LINK: rf_waddr = LINK_REG;
      default:  rf_waddr = f_rd;
    endcase
    case (ctrl.wb_sel)
      WB_MEM:  rf_wdata = dmem_rdata;
      WB_LINK: rf_wdata = pc_plus1;
      WB_KEY:  rf_wdata = kbd_data;
      default: rf_wdata = alu_y;
    endcase
  end

  // next program counter
  assign br_cond = (op == OP_BEQ) ? alu_zero : !alu_neg;

  always_comb begin
    case (ctrl.nxt_sel)
      NXT_BRANCH: pc_next = br_cond ? br_target : pc_plus1;
      NXT_JUMP:   pc_next = jmp_target;
      NXT_REG:    pc_next = rs_val;
      default:    pc_next = pc_plus1;
    endcase
  end

  assign pc_redirect = (ctrl.nxt_sel == NXT_BRANCH && br_cond) ||
                       (ctrl.nxt_sel == NXT_JUMP) || (ctrl.nxt_sel == NXT_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we;
  assign kbd_rd     = ctrl.key_re;
  assign tty_we     = ctrl.tty_we;
  assign tty_data   = rs_val[6:0];

endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk
  import cpu16_pkg::*;
#(
  parameter int W = WORD_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [W-1:0]         imem_addr,
  input logic [W-1:0]         imem_data,
  input logic                 dmem_we,
  input logic                 kbd_rd,
  input logic                 tty_we,
  input logic [6:0]           tty_data,
  input logic                 rf_we,
  input logic [REG_IDX_W-1:0] rf_waddr,
  input logic [W-1:0]         rf_wdata,
  input logic [W-1:0]         rs_val,
  input logic                 pc_redirect
);

  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  AST_PC_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> imem_addr == '0);  // R1

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !pc_redirect) |=> imem_addr == $past(imem_addr) + W'(1));  // R12

  AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_data[11:9] == 3'd0) |-> rs_val == '0);  // R11

  AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_data[15:12] == 4'hD) |-> (rf_we && rf_waddr == REG_IDX_W'(REG_CNT-1)
                                    && rf_wdata == imem_addr + W'(1)));  // R8

  AST_KEY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_rd |-> (rf_we && !tty_we && !dmem_we && rf_waddr == imem_data[5:3]));  // R9

  AST_TTY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    tty_we |-> (!rf_we && tty_data == rs_val[6:0]));  // R10

  AST_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (!rf_we && !pc_redirect));  // R5

endmodule

bind cpu16_core cpu16_core_chk u_chk (.*);

// File: tb/sim_cpu16_core.sv
`timescale 1ns/1ps
module sim_cpu16_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic [15:0] kbd_data = 16'h0;
  logic        dmem_we, kbd_rd, tty_we;
  logic [6:0]  tty_data;

  logic [15:0] imem [64];
  logic [15:0] dmem [64];
  logic [15:0] ref_mem [64];
  logic [15:0] ref_rf [8];
  logic [15:0] ref_pc;
  string       pc_tag;

  int n_chk = 0, n_bad = 0, tty_cnt = 0;
  logic [6:0] tty_last;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign imem_data  = imem[imem_addr[5:0]];
  assign dmem_rdata = dmem[dmem_addr[5:0]];

  cpu16_core u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .kbd_data(kbd_data), .kbd_rd(kbd_rd),
    .tty_data(tty_data), .tty_we(tty_we)
  );

  function automatic logic [15:0] enc_r(int op, int rs, int rt, int rd, int sh);
    return {op[3:0], rs[2:0], rt[2:0], rd[2:0], sh[2:0]};
  endfunction
  function automatic logic [15:0] enc_i(int op, int rs, int rt, int imm);
    return {op[3:0], rs[2:0], rt[2:0], imm[5:0]};
  endfunction
  function automatic logic [15:0] enc_j(int op, int tgt);
    return {op[3:0], tgt[11:0]};
  endfunction
  function automatic logic [15:0] widen6(logic [5:0] v);
    logic [15:0] r = {10'b0, v};
    if (v[5]) r = r - 16'd64;
    return r;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "pc held in reset", imem_addr, 16'h0000);
    foreach (ref_rf[i]) ref_rf[i] = 16'h0;
    ref_pc = 16'h0;
    pc_tag = "R1";
    rst_n = 1'b1;
  endtask

  // one lockstep cycle: compare outputs with the instruction model, then advance
  task automatic step(input bit rnd);
    logic [15:0] ins, a, b, imm, ea, npc, wv;
    logic [3:0]  op;
    logic [2:0]  wi;
    bit          wen, ewe, ekb, ett;
    string       tg;
    if (rnd) kbd_data = 16'($urandom);
    #1;
    chk(pc_tag, "pc", imem_addr, ref_pc);
    ins = imem[ref_pc[5:0]];
    op  = ins[15:12];
    a   = ref_rf[ins[11:9]];
    b   = ref_rf[ins[8:6]];
    imm = widen6(ins[5:0]);
    npc = ref_pc + 16'd1;
    wen = 0; ewe = 0; ekb = 0; ett = 0; wi = ins[5:3]; wv = 16'h0; ea = a + imm;
    tg  = "R12";
    case (op)
      4'h0: begin wen = 1; wi = ins[8:6]; wv = ea; end
      4'h1: begin wen = 1; wv = a + b; end
      4'h2: begin wen = 1; wv = a - b; end
      4'h3: begin wen = 1; wv = ~a; end
      4'h4: begin wen = 1; wv = a & b; end
      4'h5: begin wen = 1; wv = a << ins[2:0]; end
      4'h6: begin wen = 1; wv = a >> ins[2:0]; end
      4'h7: begin wen = 1; wi = ins[8:6]; wv = ref_mem[ea[5:0]]; end
      4'h8: ewe = 1;
      4'h9: begin tg = "R6"; if (a[15] == 1'b0) npc = ref_pc + 16'd1 + imm; end
      4'hA: begin tg = "R6"; if (a == b) npc = ref_pc + 16'd1 + imm; end
      4'hB: begin tg = "R7"; npc = {4'h0, ins[11:0]}; end
      4'hC: begin tg = "R7"; npc = a; end
      4'hD: begin tg = "R8"; wen = 1; wi = 3'd7; wv = ref_pc + 16'd1; npc = {4'h0, ins[11:0]}; end
      4'hE: begin wen = 1; ekb = 1; wv = kbd_data; end
      default: ett = 1;
    endcase
    chk("R5", "dmem_we", {15'b0, dmem_we}, {15'b0, ewe});
    if (ewe) begin
      chk("R5", "store address", dmem_addr, ea);
      chk("R5", "store data", dmem_wdata, b);
      ref_mem[ea[5:0]] = b;
      dmem[dmem_addr[5:0]] = dmem_wdata;
    end
    chk("R9", "kbd_rd", {15'b0, kbd_rd}, {15'b0, ekb});
    chk("R10", "tty_we", {15'b0, tty_we}, {15'b0, ett});
    if (ett) begin
      chk("R10", "tty_data", {9'b0, tty_data}, {9'b0, a[6:0]});
      tty_cnt++;
      tty_last = tty_data;
    end
    if (wen && wi != 3'd0) ref_rf[wi] = wv;
    ref_pc = npc;
    pc_tag = tg;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // ---------------- directed program ----------------
    foreach (imem[i]) imem[i] = enc_j(11, i);
    foreach (dmem[i]) dmem[i] = 16'hAAAA;
    dmem[41] = 16'h1234;
    imem[0]  = enc_i(0, 0, 1, 5);
    imem[1]  = enc_i(0, 0, 2, -3);
    imem[2]  = enc_r(1, 1, 2, 3, 0);
    imem[3]  = enc_r(2, 2, 1, 4, 0);
    imem[4]  = enc_r(5, 1, 0, 5, 3);
    imem[5]  = enc_r(6, 2, 0, 6, 4);
    imem[6]  = enc_r(4, 4, 6, 7, 0);
    imem[7]  = enc_i(8, 0, 3, 0);
    imem[8]  = enc_i(8, 0, 4, 1);
    imem[9]  = enc_i(8, 0, 5, 2);
    imem[10] = enc_i(8, 0, 6, 3);
    imem[11] = enc_i(8, 0, 7, 4);
    imem[12] = enc_i(0, 0, 0, 7);
    imem[13] = enc_i(8, 0, 0, 5);
    imem[14] = enc_i(7, 5, 1, 1);
    imem[15] = enc_i(8, 0, 1, 6);
    imem[16] = enc_i(10, 3, 3, 1);
    imem[17] = enc_i(0, 0, 2, 1);
    imem[18] = enc_i(8, 0, 2, 7);
    imem[19] = enc_i(9, 2, 0, 1);
    imem[20] = enc_i(0, 0, 2, 9);
    imem[21] = enc_i(8, 0, 2, 8);
    imem[22] = enc_j(13, 25);
    imem[23] = enc_i(8, 0, 7, 9);
    imem[24] = enc_j(11, 24);
    imem[25] = enc_r(15, 1, 0, 0, 0);
    imem[26] = enc_r(14, 0, 0, 3, 0);
    imem[27] = enc_i(8, 0, 3, 10);
    imem[28] = enc_r(12, 7, 0, 0, 0);
    foreach (dmem[i]) ref_mem[i] = dmem[i];
    kbd_data = 16'h0041;
    do_reset();
    for (int c = 0; c < 40; c++) step(1'b0);
    chk("R2", "add result", dmem[0], 16'h0002);
    chk("R2", "sub result", dmem[1], 16'hFFF8);
    chk("R4", "sll result", dmem[2], 16'h0028);
    chk("R4", "srl zero fill", dmem[3], 16'h0FFF);
    chk("R2", "and result", dmem[4], 16'h0FF8);
    chk("R11", "r0 after write", dmem[5], 16'h0000);
    chk("R3", "lw via offset", dmem[6], 16'h1234);
    chk("R3", "addi negative", dmem[7], 16'hFFFD);
    chk("R6", "beq taken skips", dmem[7], 16'hFFFD);
    chk("R6", "bgez not taken", dmem[8], 16'h0009);
    chk("R8", "link value", dmem[9], 16'd23);
    chk("R9", "keyboard value", dmem[10], 16'h0041);
    chk("R10", "tty strobes", 16'(tty_cnt), 16'd1);
    chk("R10", "tty char", {9'b0, tty_last}, 16'h0034);
    chk("R7", "halt address", imem_addr, 16'd24);
    // ---------------- random programs ----------------
    for (int r = 0; r < 6; r++) begin
      foreach (imem[i]) imem[i] = 16'($urandom);
      foreach (dmem[i]) begin dmem[i] = 16'($urandom); ref_mem[i] = dmem[i]; end
      do_reset();
      for (int c = 0; c < 4000; c++) step(1'b1);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule